// File: doc/BRIEF.md
# Exception and Interrupt Control Coprocessor

This block is the system-control coprocessor of a 32-bit pipelined core. It holds four control registers: the faulting data address, the processor status word, the exception cause word and the exception return PC. Software reaches them by register number through a move-to / move-from access port. The pipeline sees a redirect request whenever an exception or interrupt is taken or a return from exception is executed.

Eight interrupt request lines are registered every cycle into the pending field of the cause word. An interrupt is taken when a pending line is also enabled in the mask, the global enable is set and the block is not already at exception level. The pipeline reports synchronous exceptions with a code. It also presents the PC of the instruction at the commit point, a flag that says whether that instruction sits in a branch delay slot, and the memory address involved. On any taken event the block records the cause. It then sets the exception-level bit and requests a redirect to a fixed handler vector in the same cycle.

Top module: `excu_top`

## Requirements
- R1: After reset every implemented register reads 0 and no redirect is requested.
- R2: Register numbers 8 (bad address), 12 (status), 13 (cause) and 14 (return PC) are readable. Any other number reads 0, and writes to it are ignored. The cause register is read-only. Status has these writable fields: interrupt mask in bits 15:8, user mode in bit 4, exception level in bit 1 and interrupt enable in bit 0. All other status bits read 0.
- R3: The cause register has this layout: branch-delay flag in bit 31, pending bits in 15:8 and exception code in 6:2. All other bits are 0. The pending bits equal the request lines as sampled at the previous clock edge.
- R4: An interrupt redirect is requested in the same cycle when (pending AND mask) is nonzero, enable is 1 and exception level is 0. The recorded code is 0.
- R5: A synchronous exception report raises a redirect in the same cycle, with target equal to the VECTOR parameter (default 0x80000180). The reported code is stored in cause bits 6:2, and exception level becomes 1.
- R6: On a taken event the return PC register receives the commit PC, and the branch-delay flag is cleared. If the delay-slot flag is set, the register receives PC minus 4 and the branch-delay flag is set.
- R7: The bad-address register is loaded with the reported address only for codes 4 and 5 (address error on load/fetch or on store). For every other code it keeps its value.
- R8: A synchronous exception and an interrupt in the same cycle record the synchronous code.
- R9: While exception level is 1, interrupts raise no redirect. Synchronous exceptions are still taken and update the registers.
- R10: A return pulse with no exception in that cycle clears exception level and raises a redirect whose target is the return PC register.
- R11: A register write in the same cycle as a taken event is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cp_rd_sel | input | 5 | Register number for reads |
| cp_rd_data | output | 32 | Read data (combinational) |
| cp_wr_en | input | 1 | Register write strobe |
| cp_wr_sel | input | 5 | Register number for writes |
| cp_wr_data | input | 32 | Write data |
| irq_lines | input | 8 | Interrupt request lines |
| sync_valid | input | 1 | Synchronous exception report |
| sync_code | input | 5 | Code of the reported exception |
| exc_pc | input | 32 | PC of the instruction at the commit point |
| exc_in_delay | input | 1 | That instruction sits in a branch delay slot |
| exc_addr | input | 32 | Memory address involved in the report |
| eret_pulse | input | 1 | Return from exception |
| redirect_valid | output | 1 | Fetch redirect request |
| redirect_target | output | 32 | Redirect target address |
| exc_level | output | 1 | Current exception-level bit |
| user_mode | output | 1 | Current user-mode bit |

## Verification
The hardest situations to reach from the ports are the collisions within a single cycle: an exception colliding with a pending interrupt, with a register write, or with exception level already set. Interrupts need a sampled pending bit, so the bench raises a line one cycle ahead. It then lines the synchronous report up with that cycle, or first lets an interrupt set exception level, and only afterwards fires the report. A sweep over each line, four mask patterns, the enable bit and the level bit covers the interrupt gate.

// File: rtl/excu_pkg.sv
package excu_pkg;
  localparam int XLEN   = 32;
  localparam int IRQ_W  = 8;
  localparam int CODE_W = 5;
  localparam int SEL_W  = 5;

  localparam logic [SEL_W-1:0] SEL_BADV  = 5'd8;
  localparam logic [SEL_W-1:0] SEL_STAT  = 5'd12;
  localparam logic [SEL_W-1:0] SEL_CAUSE = 5'd13;
  localparam logic [SEL_W-1:0] SEL_EPC   = 5'd14;

  localparam logic [CODE_W-1:0] EC_INT  = 5'd0;
  localparam logic [CODE_W-1:0] EC_ADEL = 5'd4;
  localparam logic [CODE_W-1:0] EC_ADES = 5'd5;

  typedef struct packed {
    logic [IRQ_W-1:0] mask;
    logic             um;
    logic             exl;
    logic             ie;
  } status_t;

  function automatic logic [XLEN-1:0] status_word(input status_t s);
    return {16'b0, s.mask, 3'b0, s.um, 2'b0, s.exl, s.ie};
  endfunction

  function automatic status_t status_unpack(input logic [XLEN-1:0] w);
    status_t s;
    s.mask = w[15:8];
    s.um   = w[4];
    s.exl  = w[1];
    s.ie   = w[0];
    return s;
  endfunction

  function automatic logic [XLEN-1:0] cause_word(input logic bd,
                                                 input logic [IRQ_W-1:0] pend,
                                                 input logic [CODE_W-1:0] code);
    return {bd, 15'b0, pend, 1'b0, code, 2'b0};
  endfunction

  function automatic logic [XLEN-1:0] return_pc(input logic [XLEN-1:0] pc,
                                                input logic in_delay);
    return in_delay ? pc - 32'd4 : pc;
  endfunction

  function automatic logic is_addr_err(input logic [CODE_W-1:0] code);
    return (code == EC_ADEL) || (code == EC_ADES);
  endfunction
endpackage

// File: rtl/excu_gate.sv
module excu_gate
  import excu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IRQ_W-1:0]  pend,
  input  logic [IRQ_W-1:0]  mask,
  input  logic              ie,
  input  logic              exl,
  input  logic              sync_valid,
  input  logic [CODE_W-1:0] sync_code,
  input  logic              eret,
  output logic              int_req,
  output logic              take,
  output logic [CODE_W-1:0] take_code,
  output logic              eret_eff
);
  always_comb begin
    int_req   = (|(pend & mask)) & ie & ~exl;
    take      = sync_valid | int_req;
    take_code = sync_valid ? sync_code : EC_INT;
    eret_eff  = eret & ~take;
  end

  // R9
  exl_blocks_int_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && exl) |-> sync_valid);

  // R8
  sync_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync_valid |-> (take_code == sync_code));
endmodule

// File: rtl/excu_regs.sv
module excu_regs
  import excu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IRQ_W-1:0]  irq_lines,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic [XLEN-1:0]   wr_data,
  input  logic              take,
  input  logic [CODE_W-1:0] take_code,
  input  logic [XLEN-1:0]   exc_pc,
  input  logic              exc_in_delay,
  input  logic [XLEN-1:0]   exc_addr,
  input  logic              eret_eff,
  output status_t           status_q,
  output logic [IRQ_W-1:0]  pend_q,
  output logic              bd_q,
  output logic [CODE_W-1:0] code_q,
  output logic [XLEN-1:0]   epc_q,
  output logic [XLEN-1:0]   badv_q
);
  logic wr_ok;
  assign wr_ok = wr_en & ~take;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status_q <= '0;
      pend_q   <= '0;
      bd_q     <= 1'b0;
      code_q   <= '0;
      epc_q    <= '0;
      badv_q   <= '0;
    end else begin
      pend_q <= irq_lines;
      if (take) begin
        status_q.exl <= 1'b1;
        code_q       <= take_code;
        bd_q         <= exc_in_delay;
        epc_q        <= return_pc(exc_pc, exc_in_delay);
        if (is_addr_err(take_code)) badv_q <= exc_addr;
      end else begin
        if (wr_ok) begin
          case (wr_sel)
            SEL_STAT: status_q <= status_unpack(wr_data);
            SEL_EPC:  epc_q    <= wr_data;
            SEL_BADV: badv_q   <= wr_data;
            default: ;
          endcase
        end
        if (eret_eff) status_q.exl <= 1'b0;
      end
    end
  end

  // R5
  exl_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> status_q.exl);

  // R10
  exl_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eret_eff |=> !status_q.exl);

  // R7
  badv_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && is_addr_err(take_code)) |=> (badv_q == $past(exc_addr)));

  // R7
  badv_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !is_addr_err(take_code)) |=> $stable(badv_q));

  // R6
  bd_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (bd_q == $past(exc_in_delay)));

  // R11
  write_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && wr_en && wr_sel == SEL_STAT) |=> status_q.exl);
endmodule

// File: rtl/excu_readmux.sv
module excu_readmux
  import excu_pkg::*;
(
  input  logic [SEL_W-1:0]  sel,
  input  status_t           status_q,
  input  logic [IRQ_W-1:0]  pend_q,
  input  logic              bd_q,
  input  logic [CODE_W-1:0] code_q,
  input  logic [XLEN-1:0]   epc_q,
  input  logic [XLEN-1:0]   badv_q,
  output logic [XLEN-1:0]   rd_data
);
  always_comb begin
    case (sel)
      SEL_BADV:  rd_data = badv_q;
      SEL_STAT:  rd_data = status_word(status_q);
      SEL_CAUSE: rd_data = cause_word(bd_q, pend_q, code_q);
      SEL_EPC:   rd_data = epc_q;
      default:   rd_data = '0;
    endcase
  end
endmodule

// File: rtl/excu_top.sv
module excu_top
  import excu_pkg::*;
#(
  parameter logic [31:0] VECTOR = 32'h8000_0180
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [4:0]  cp_rd_sel,
  output logic [31:0] cp_rd_data,
  input  logic        cp_wr_en,
  input  logic [4:0]  cp_wr_sel,
  input  logic [31:0] cp_wr_data,
  input  logic [7:0]  irq_lines,
  input  logic        sync_valid,
  input  logic [4:0]  sync_code,
  input  logic [31:0] exc_pc,
  input  logic        exc_in_delay,
  input  logic [31:0] exc_addr,
  input  logic        eret_pulse,
  output logic        redirect_valid,
  output logic [31:0] redirect_target,
  output logic        exc_level,
  output logic        user_mode
);
  status_t           status_q;
  logic [IRQ_W-1:0]  pend_q;
  logic              bd_q;
  logic [CODE_W-1:0] code_q;
  logic [XLEN-1:0]   epc_q;
  logic [XLEN-1:0]   badv_q;
  logic              int_req;
  logic              take;
  logic [CODE_W-1:0] take_code;
  logic              eret_eff;

  excu_gate u_gate (
    .clk(clk), .rst_n(rst_n), .pend(pend_q), .mask(status_q.mask),
    .ie(status_q.ie), .exl(status_q.exl), .sync_valid(sync_valid),
    .sync_code(sync_code), .eret(eret_pulse), .int_req(int_req),
    .take(take), .take_code(take_code), .eret_eff(eret_eff)
  );

  excu_regs u_regs (
    .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines), .wr_en(cp_wr_en),
    .wr_sel(cp_wr_sel), .wr_data(cp_wr_data), .take(take),
    .take_code(take_code), .exc_pc(exc_pc), .exc_in_delay(exc_in_delay),
    .exc_addr(exc_addr), .eret_eff(eret_eff), .status_q(status_q),
    .pend_q(pend_q), .bd_q(bd_q), .code_q(code_q), .epc_q(epc_q),
    .badv_q(badv_q)
  );

  excu_readmux u_rd (
    .sel(cp_rd_sel), .status_q(status_q), .pend_q(pend_q), .bd_q(bd_q),
    .code_q(code_q), .epc_q(epc_q), .badv_q(badv_q), .rd_data(cp_rd_data)
  );

  assign redirect_valid  = take | eret_eff;
  assign redirect_target = take ? VECTOR : epc_q;
  assign exc_level       = status_q.exl;
  assign user_mode       = status_q.um;

  // R10
  eret_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (redirect_valid && !take) |-> (redirect_target == epc_q));

  // R5
  vector_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync_valid |-> (redirect_valid && redirect_target == VECTOR));

  // R4
  int_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (redirect_valid && !sync_valid && !eret_pulse) |-> (!exc_level && int_req));
endmodule

// File: tb/excu_top_bench.sv
`timescale 1ns/100ps
module excu_top_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [4:0]  cp_rd_sel;
  logic [31:0] cp_rd_data;
  logic        cp_wr_en;
  logic [4:0]  cp_wr_sel;
  logic [31:0] cp_wr_data;
  logic [7:0]  irq_lines;
  logic        sync_valid;
  logic [4:0]  sync_code;
  logic [31:0] exc_pc;
  logic        exc_in_delay;
  logic [31:0] exc_addr;
  logic        eret_pulse;
  logic        redirect_valid;
  logic [31:0] redirect_target;
  logic        exc_level;
  logic        user_mode;

  localparam logic [31:0] VEC = 32'h8000_0180;
  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  excu_top u_excu_top (
    .clk(clk), .rst_n(rst_n), .cp_rd_sel(cp_rd_sel), .cp_rd_data(cp_rd_data),
    .cp_wr_en(cp_wr_en), .cp_wr_sel(cp_wr_sel), .cp_wr_data(cp_wr_data),
    .irq_lines(irq_lines), .sync_valid(sync_valid), .sync_code(sync_code),
    .exc_pc(exc_pc), .exc_in_delay(exc_in_delay), .exc_addr(exc_addr),
    .eret_pulse(eret_pulse), .redirect_valid(redirect_valid),
    .redirect_target(redirect_target), .exc_level(exc_level),
    .user_mode(user_mode)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic chkeq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    chk(act === exp, tag, act, exp);
  endtask

  task automatic rd(input logic [4:0] sel, output logic [31:0] val);
    cp_rd_sel = sel;
    #0.5;
    val = cp_rd_data;
  endtask

  function automatic logic [31:0] cause_exp(input logic bd, input logic [7:0] p,
                                            input logic [4:0] c);
    return (32'(bd) << 31) | (32'(p) << 8) | (32'(c) << 2);
  endfunction

  task automatic idle();
    cp_wr_en = 0; sync_valid = 0; eret_pulse = 0;
  endtask

  task automatic wr(input logic [4:0] sel, input logic [31:0] d);
    cp_wr_en = 1; cp_wr_sel = sel; cp_wr_data = d;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=%08h expected=%08h", 32'd0, 32'd1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [4:0]  codes [10] = '{5'd4, 5'd5, 5'd6, 5'd7, 5'd8, 5'd9, 5'd10, 5'd12, 5'd13, 5'd0};
    rst_n = 0; irq_lines = 0; exc_pc = 0; exc_in_delay = 0; exc_addr = 0;
    sync_code = 0; cp_wr_sel = 0; cp_wr_data = 0; cp_rd_sel = 0;
    idle();
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    // R1 reset state
    rd(5'd8, v);  chkeq("R1 badv", v, 0);
    rd(5'd12, v); chkeq("R1 status", v, 0);
    rd(5'd13, v); chkeq("R1 cause", v, 0);
    rd(5'd14, v); chkeq("R1 epc", v, 0);
    chkeq("R1 redirect", 32'(redirect_valid), 0);

    // R2 field masking and unimplemented numbers
    wr(5'd12, 32'hFFFF_FFFE);
    @(negedge clk); wr(5'd9, 32'h1234_5678);
    @(negedge clk); wr(5'd13, 32'hFFFF_FFFF);
    @(negedge clk); idle();
    rd(5'd12, v); chkeq("R2 status fields", v, 32'h0000_FF12);
    chkeq("R2 user mode pin", 32'(user_mode), 1);
    rd(5'd9, v);  chkeq("R2 unimplemented", v, 0);
    rd(5'd13, v); chkeq("R2 cause read-only", v, 0);
    wr(5'd12, 32'h0); eret_pulse = 1;
    @(negedge clk); idle();

    // R4 R3 interrupt gate sweep
    for (int line = 0; line < 8; line++) begin
      for (int mp = 0; mp < 4; mp++) begin
        for (int e = 0; e < 2; e++) begin
          for (int ie = 0; ie < 2; ie++) begin
            logic [7:0] m;
            logic [7:0] bitv;
            logic exp;
            bitv = 8'(1 << line);
            m = (mp == 0) ? 8'h00 : (mp == 1) ? 8'hFF : (mp == 2) ? bitv : ~bitv;
            irq_lines = 0; eret_pulse = 1;
            @(negedge clk); idle();
            wr(5'd12, {16'b0, m, 6'b0, e[0], ie[0]});
            @(negedge clk); idle();
            irq_lines = bitv;
            @(negedge clk);
            exp = m[line] & ie[0] & ~e[0];
            rd(5'd13, v); chkeq("R3 pending", {24'b0, v[15:8]}, {24'b0, bitv});
            if (e == 1) chkeq("R9 no int at level", 32'(redirect_valid), 0);
            else chkeq("R4 int gate", 32'(redirect_valid), 32'(exp));
            if (exp) begin
              @(negedge clk);
              rd(5'd13, v); chkeq("R4 code zero", {27'b0, v[6:2]}, 0);
              chkeq("R4 level set", 32'(exc_level), 1);
            end
          end
        end
      end
    end
    irq_lines = 0; eret_pulse = 1;
    @(negedge clk); idle();
    wr(5'd12, 32'h0);
    @(negedge clk); idle();

    // R5 R6 R7 synchronous sweep
    for (int k = 0; k < 10; k++) begin
      for (int d = 0; d < 2; d++) begin
        logic [31:0] pc;
        logic [31:0] ad;
        logic [31:0] sent;
        pc = 32'h0040_1000 + 32'(k * 64 + d * 16);
        ad = 32'h1000_0003 + 32'(k);
        sent = 32'hDEAD_0000 + 32'(k);
        wr(5'd8, sent); eret_pulse = 1;
        @(negedge clk); idle();
        sync_valid = 1; sync_code = codes[k]; exc_pc = pc;
        exc_in_delay = d[0]; exc_addr = ad;
        #0.5;
        chkeq("R5 redirect", 32'(redirect_valid), 1);
        chkeq("R5 vector", redirect_target, VEC);
        @(negedge clk); idle();
        rd(5'd13, v); chkeq("R6 R5 cause", v, cause_exp(d[0], 8'h00, codes[k]));
        rd(5'd14, v); chkeq("R6 epc", v, d ? pc - 32'd4 : pc);
        rd(5'd8, v);
        chkeq("R7 badv", v, (codes[k] == 5'd4 || codes[k] == 5'd5) ? ad : sent);
        chkeq("R5 level", 32'(exc_level), 1);
      end
    end

    // R10 return
    eret_pulse = 1;
    #0.5;
    chkeq("R10 redirect", 32'(redirect_valid), 1);
    chkeq("R10 target", redirect_target, 32'h0040_1000 + 32'(9 * 64 + 16) - 32'd4);
    @(negedge clk); idle();
    chkeq("R10 level cleared", 32'(exc_level), 0);

    // R8 priority
    wr(5'd12, 32'h0000_FF01); irq_lines = 8'h01;
    @(negedge clk); idle();
    sync_valid = 1; sync_code = 5'd12; exc_pc = 32'h0000_2000; exc_in_delay = 0;
    @(negedge clk); idle();
    rd(5'd13, v); chkeq("R8 sync code wins", {27'b0, v[6:2]}, 32'd12);

    // R9 sync still taken at level, pending ignored
    chkeq("R9 no int redirect", 32'(redirect_valid), 0);
    sync_valid = 1; sync_code = 5'd8; exc_pc = 32'h0000_3000;
    #0.5;
    chkeq("R9 sync redirect", 32'(redirect_valid), 1);
    @(negedge clk); idle();
    rd(5'd13, v); chkeq("R9 code", {27'b0, v[6:2]}, 32'd8);
    rd(5'd14, v); chkeq("R9 epc", v, 32'h0000_3000);

    // R11 write in exception cycle dropped
    wr(5'd14, 32'hCAFE_F00D);
    sync_valid = 1; sync_code = 5'd9; exc_pc = 32'h0000_4000;
    @(negedge clk); idle();
    rd(5'd14, v); chkeq("R11 epc write dropped", v, 32'h0000_4000);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule